// File: doc/BRIEF.md
# 16-bit Compare/Capture Timer with Byte-Wide Register Access

This block is a 16-bit up-counter for a CPU with an 8-bit register bus. It has two compare channels (A and B), one capture channel and an overflow detector. Each event source has a sticky flag and a mask bit, and each raises an interrupt request when its flag, its mask bit and a global enable are all set. The counter advances once for every cycle in which the timer-clock enable `tick` is high. The clock division that produces `tick` sits outside the block.

The counter, the two compare values and the capture value are all 16 bits wide. Software reaches them through byte addresses. All four go through one shared 8-bit holding byte, so both halves of a value change or are sampled in the same cycle. Three counting modes are provided: free-running wrap, clear after a match with compare A, and clear after a match with the capture register, which then acts as TOP. Compare channels also emit one-cycle match strobes for downstream waveform logic. Software can force those strobes without raising a flag.

Top module: `tmr16_cc`

## Requirements
- R1: After synchronous reset, every readable register (addresses 0 to 9) reads 0x00 and `irq_req` is 0.
- R2: Address map: counter 0/1, compare A 2/3, compare B 4/5, capture 6/7, mask 8, flags 9, with the low byte at the even address. Writing a high byte only loads the shared holding byte. The 16-bit register is unchanged until a low-byte write commits {holding byte, low byte}. This holds for any pairing of addresses, because the holding byte is shared.
- R3: Reading a low byte returns bits 7:0 and copies bits 15:8 into the holding byte. A later high-byte read returns that copy, even if the counter has moved since. Read data appears the cycle after `bus_rd`.
- R4: In free mode (`mode`=0) the counter adds one per tick and wraps from 0xFFFF to 0. The tick taken at 0xFFFF sets the overflow flag, which is bit 2.
- R5: In clear-on-A mode (`mode`=1), the tick taken while the counter equals compare A returns it to 0. A counter written above compare A counts on to 0xFFFF, wraps and sets overflow.
- R6: A tick taken while the counter equals compare A sets flag bit 4. For compare B it sets flag bit 3. The same tick pulses `match_a` or `match_b` for one cycle.
- R7: After a counter write, the first following tick raises no compare flag and no match strobe on either channel.
- R8: `force_a` or `force_b` pulses the matching strobe one cycle later and leaves the flags unchanged.
- R9: In modes 0 and 1, a rising edge on the selected source loads the capture register with the counter and sets flag bit 5. The source is `cap_pin` when `cap_sel`=0 and `cmp_pin` when `cap_sel`=1.
- R10: In clear-on-capture mode (`mode`=2), the capture register is TOP. The tick taken at TOP clears the counter and sets bit 5. Source edges do not change the capture register.
- R11: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. `irq_ack` bits {3:cap, 2:A, 1:B, 0:ovf} also clear flags. A new event in the same cycle as a clear wins.
- R12: Mask bits sit at the same positions as the flag bits. `irq_req` uses the `irq_ack` bit order. A request bit is high exactly when its flag, its mask bit and `gie` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mode | input | 2 | 0 free, 1 clear on A, 2 clear on capture |
| cap_pin | input | 1 | Capture input (synchronous) |
| cmp_pin | input | 1 | Alternate capture source (comparator output) |
| cap_sel | input | 1 | Capture source select |
| force_a | input | 1 | Forced match strobe, channel A |
| force_b | input | 1 | Forced match strobe, channel B |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Interrupt acknowledge, clears flags |
| irq_req | output | 4 | Interrupt requests |
| match_a | output | 1 | Compare A match strobe |
| match_b | output | 1 | Compare B match strobe |

## Verification
The hardest situations to reach are the ones where two things land on the same timer clock. One is a counter write landing on the very count that would have matched. The other is an acknowledge arriving in the same cycle as a new overflow. Directed sequences reach them by writing the counter exactly onto a compare value and stepping `tick` one pulse at a time. They also raise `irq_ack` together with the tick that wraps 0xFFFF. A seeded random loop then places both compare values at random small offsets from a random counter start. This exercises the blocked first tick, overflow and the match window together, against a bench model of which counts each tick visits.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [3:0] {
    A_CNT_L = 4'd0, A_CNT_H = 4'd1, A_CMPA_L = 4'd2, A_CMPA_H = 4'd3,
    A_CMPB_L = 4'd4, A_CMPB_H = 4'd5, A_CAP_L = 4'd6, A_CAP_H = 4'd7,
    A_MASK = 4'd8, A_FLAG = 4'd9
  } addr_e;

  typedef enum logic [1:0] {
    M_FREE = 2'd0, M_CLR_A = 2'd1, M_CLR_CAP = 2'd2, M_RSVD = 2'd3
  } mode_e;

  // event vector order: 3 capture, 2 compare A, 1 compare B, 0 overflow
  localparam int unsigned NEV      = 4;
  localparam int unsigned FLAG_LSB = 2;
endpackage

// File: rtl/tmr16_wide_port.sv
module tmr16_wide_port
  import tmr16_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              addr,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [DW-1:0]           wdata,
  input  logic [3:0][2*DW-1:0]    val,
  input  logic [NEV-1:0]          flags,
  input  logic [NEV-1:0]          mask,
  output logic [3:0]              wr16,
  output logic [2*DW-1:0]         wr16_data,
  output logic                    wr_mask,
  output logic                    wr_flag,
  output logic [DW-1:0]           rdata
);
  localparam int unsigned CW = 2 * DW;

  logic [DW-1:0] temp_q;
  logic          wide, lo;
  logic [1:0]    idx;

  assign wide = ~addr[3];
  assign lo   = ~addr[0];
  assign idx  = addr[2:1];

  always_comb begin
    wr16 = '0;
    if (wr && wide && lo) wr16[idx] = 1'b1;
  end
  assign wr16_data = {temp_q, wdata};
  assign wr_mask   = wr && (addr == A_MASK);
  assign wr_flag   = wr && (addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr && wide && !lo)      temp_q <= wdata;
      else if (rd && wide && lo)  temp_q <= val[idx][CW-1:DW];
      if (rd) begin
        if (wide && lo)             rdata <= val[idx][DW-1:0];
        else if (wide)              rdata <= temp_q;
        else if (addr == A_MASK)    rdata <= DW'({mask, 2'b00});
        else if (addr == A_FLAG)    rdata <= DW'({flags, 2'b00});
        else                        rdata <= '0;
      end
    end
  end

  p_low_read_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && wide && lo && !wr) |=> temp_q == $past(val[idx][CW-1:DW]));
  p_high_write_only_temp_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && wide && !lo) |=> (temp_q == $past(wdata)) && $stable(val));
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [1:0]     mode,
  input  logic [3:0]     wr16,
  input  logic [CW-1:0]  wr_data,
  input  logic           cap_pin,
  input  logic           cmp_pin,
  input  logic           cap_sel,
  input  logic           force_a,
  input  logic           force_b,
  output logic [CW-1:0]  cnt,
  output logic [CW-1:0]  cmp_a,
  output logic [CW-1:0]  cmp_b,
  output logic [CW-1:0]  cap,
  output logic [NEV-1:0] ev,
  output logic           match_a,
  output logic           match_b
);
  localparam logic [CW-1:0] MAXV = '1;

  mode_e         m;
  logic [CW-1:0] cnt_q, cap_q, top;
  logic [CW-1:0] cmp_q [2];
  logic [1:0]    ev_cmp, mstr, frc;
  logic          blk, cnt_wr, tick_eff, use_top, at_top;
  logic          ev_ovf, ev_cap, src, src_q, edge_ev;

  assign m        = mode_e'(mode);
  assign cnt_wr   = wr16[0];
  assign tick_eff = tick && !cnt_wr;
  assign frc      = {force_b, force_a};

  always_comb begin
    use_top = 1'b0;
    top     = MAXV;
    case (m)
      M_CLR_A:   begin use_top = 1'b1; top = cmp_q[0]; end
      M_CLR_CAP: begin use_top = 1'b1; top = cap_q;    end
      default:   ;
    endcase
  end
  assign at_top = use_top && (cnt_q == top);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      blk    <= 1'b0;
      ev_ovf <= 1'b0;
    end else begin
      ev_ovf <= tick_eff && (cnt_q == MAXV);
      if (cnt_wr) begin
        cnt_q <= wr_data;
        blk   <= 1'b1;
      end else if (tick) begin
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        blk   <= 1'b0;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [CW-1:0] val_q;
    logic          ev_q, m_q, hit;
    assign hit = tick_eff && !blk && (cnt_q == val_q);
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
        ev_q  <= 1'b0;
        m_q   <= 1'b0;
      end else begin
        if (wr16[1+ch]) val_q <= wr_data;
        ev_q <= hit;
        m_q  <= hit || frc[ch];
      end
    end
    assign cmp_q[ch]  = val_q;
    assign ev_cmp[ch] = ev_q;
    assign mstr[ch]   = m_q;
  end

  assign src     = cap_sel ? cmp_pin : cap_pin;
  assign edge_ev = src && !src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      src_q  <= 1'b0;
      ev_cap <= 1'b0;
    end else begin
      src_q <= src;
      if (wr16[3])                          cap_q <= wr_data;
      else if (edge_ev && m != M_CLR_CAP)   cap_q <= cnt_q;
      if (m == M_CLR_CAP) ev_cap <= tick_eff && at_top;
      else                ev_cap <= edge_ev && !wr16[3];
    end
  end

  assign cnt     = cnt_q;
  assign cmp_a   = cmp_q[0];
  assign cmp_b   = cmp_q[1];
  assign cap     = cap_q;
  assign ev      = {ev_cap, ev_cmp[0], ev_cmp[1], ev_ovf};
  assign match_a = mstr[0];
  assign match_b = mstr[1];

  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && cnt_q == MAXV) |=> (cnt_q == '0) && ev[0]);
  p_clear_on_a_r5: assert property (@(posedge clk) disable iff (rst)
    (m == M_CLR_A && tick && !cnt_wr && cnt_q == cmp_q[0]) |=> cnt_q == '0);
  p_block_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    (blk && tick && !cnt_wr) |=> !ev[2] && !ev[1] && !(match_a && !$past(force_a)));
  p_capture_load_r9: assert property (@(posedge clk) disable iff (rst)
    (edge_ev && m != M_CLR_CAP && !wr16[3]) |=> (cap_q == $past(cnt_q)) && ev[3]);
  p_top_capture_held_r10: assert property (@(posedge clk) disable iff (rst)
    (m == M_CLR_CAP && !wr16[3]) |=> cap_q == $past(cap_q));
endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq
  import tmr16_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] ack,
  input  logic           wr_mask,
  input  logic           wr_flag,
  input  logic [NEV-1:0] wbits,
  input  logic           gie,
  output logic [NEV-1:0] flags,
  output logic [NEV-1:0] mask,
  output logic [NEV-1:0] irq_req
);
  logic [NEV-1:0] flags_q, mask_q, clr;

  assign clr = ack | (wr_flag ? wbits : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | ev;
      if (wr_mask) mask_q <= wbits;
    end
  end

  assign flags   = flags_q;
  assign mask    = mask_q;
  assign irq_req = flags_q & mask_q & {NEV{gie}};

  for (genvar i = 0; i < NEV; i++) begin : g_chk
    p_flag_only_from_event_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(flags_q[i]) |-> $past(ev[i]));
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !ev[i]) |=> !flags_q[i]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/tmr16_cc.sv
module tmr16_cc
  import tmr16_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [3:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [1:0]      mode,
  input  logic            cap_pin,
  input  logic            cmp_pin,
  input  logic            cap_sel,
  input  logic            force_a,
  input  logic            force_b,
  input  logic            gie,
  input  logic [3:0]      irq_ack,
  output logic [3:0]      irq_req,
  output logic            match_a,
  output logic            match_b
);
  localparam int unsigned CW = 2 * DW;

  logic [3:0]          wr16;
  logic [CW-1:0]       wr16_data, cnt, cmp_a, cmp_b, cap;
  logic [3:0][CW-1:0]  wide_val;
  logic [NEV-1:0]      ev, flags, mask;
  logic                wr_mask, wr_flag;

  assign wide_val = {cap, cmp_b, cmp_a, cnt};

  tmr16_wide_port #(.DW(DW)) u_port (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .val(wide_val), .flags(flags), .mask(mask),
    .wr16(wr16), .wr16_data(wr16_data), .wr_mask(wr_mask),
    .wr_flag(wr_flag), .rdata(bus_rdata)
  );

  tmr16_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr16(wr16),
    .wr_data(wr16_data), .cap_pin(cap_pin), .cmp_pin(cmp_pin),
    .cap_sel(cap_sel), .force_a(force_a), .force_b(force_b),
    .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b), .cap(cap), .ev(ev),
    .match_a(match_a), .match_b(match_b)
  );

  tmr16_irq u_irq (
    .clk(clk), .rst(rst), .ev(ev), .ack(irq_ack), .wr_mask(wr_mask),
    .wr_flag(wr_flag), .wbits(bus_wdata[FLAG_LSB +: NEV]), .gie(gie),
    .flags(flags), .mask(mask), .irq_req(irq_req)
  );
endmodule

// File: tb/tmr16_cc_tb_top.sv
module tmr16_cc_tb_top;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] mode = '0;
  logic       cap_pin = 1'b0, cmp_pin = 1'b0, cap_sel = 1'b0;
  logic       force_a = 1'b0, force_b = 1'b0, gie = 1'b0;
  logic [3:0] irq_ack = '0, irq_req;
  logic       match_a, match_b;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  logic last_ma, last_mb;

  always #4 clk = ~clk;

  tmr16_cc dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode(mode), .cap_pin(cap_pin), .cmp_pin(cmp_pin), .cap_sel(cap_sel),
    .force_a(force_a), .force_b(force_b), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .match_a(match_a), .match_b(match_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr16(input logic [3:0] base, input logic [15:0] v);
    wr8(base + 4'd1, v[15:8]);
    wr8(base, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] base, output logic [15:0] v);
    logic [7:0] l, h;
    rd8(base, l);
    rd8(base + 4'd1, h);
    v = {h, l};
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; last_ma = match_a; last_mb = match_b;
    end
  endtask

  task automatic clr_flags();
    wr8(4'd9, 8'h3C);
  endtask

  task automatic pulse_src(input bit use_cmp);
    @(negedge clk); if (use_cmp) cmp_pin = 1'b1; else cap_pin = 1'b1;
    @(negedge clk); cmp_pin = 1'b0; cap_pin = 1'b0;
  endtask

  function automatic bit hit_after_block(input int c, input int n, input int v);
    for (int k = 1; k < n; k++) if (((c + k) & 16'hFFFF) == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ovf_in(input int c, input int n);
    for (int k = 0; k < n; k++) if (((c + k) & 16'hFFFF) == 16'hFFFF) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd8(a[3:0], b);
      chk("R1 reset register", b, 0);
    end
    chk("R1 irq after reset", irq_req, 0);

    // R2 high byte alone does not commit; shared holding byte
    wr8(4'd3, 8'hAB);
    rd16(4'd2, w);
    chk("R2 high write alone", w, 16'h0000);
    wr16(4'd2, 16'hABCD);
    rd16(4'd2, w);
    chk("R2 compare A commit", w, 16'hABCD);
    wr8(4'd1, 8'h34);
    wr8(4'd4, 8'h56);
    rd16(4'd4, w);
    chk("R2 shared holding byte", w, 16'h3456);

    // R3 latched high byte
    wr16(4'd0, 16'h12FF);
    rd8(4'd0, b);
    chk("R3 low byte", b, 8'hFF);
    do_tick(1);
    rd8(4'd1, b);
    chk("R3 latched high byte", b, 8'h12);
    rd16(4'd0, w);
    chk("R4 counter advanced", w, 16'h1300);

    // R7 write blocks the next compare; R6 flags and strobes
    wr16(4'd2, 16'h0100);
    wr16(4'd4, 16'h0102);
    wr16(4'd0, 16'h0100);
    clr_flags();
    do_tick(1);
    chk("R7 blocked match strobe", last_ma, 0);
    rd8(4'd9, b);
    chk("R7 blocked flag", b, 8'h00);
    wr16(4'd0, 16'h00FF);
    clr_flags();
    do_tick(2);
    chk("R6 match_a strobe", last_ma, 1);
    rd8(4'd9, b);
    chk("R6 flag A", b, 8'h10);
    do_tick(2);
    chk("R6 match_b strobe", last_mb, 1);
    rd8(4'd9, b);
    chk("R6 flag B", b, 8'h18);

    // R8 forced strobes raise no flag
    clr_flags();
    @(negedge clk); force_a = 1'b1;
    @(negedge clk); force_a = 1'b0;
    chk("R8 force_a strobe", match_a, 1);
    @(negedge clk); force_b = 1'b1;
    @(negedge clk); force_b = 1'b0;
    chk("R8 force_b strobe", match_b, 1);
    rd8(4'd9, b);
    chk("R8 no flag from force", b, 8'h00);

    // R4 overflow
    wr16(4'd0, 16'hFFFE);
    clr_flags();
    do_tick(2);
    rd16(4'd0, w);
    chk("R4 wrap to zero", w, 0);
    rd8(4'd9, b);
    chk("R4 overflow flag", b, 8'h04);

    // R11 write-one-to-clear and acknowledge
    wr8(4'd9, 8'h00);
    rd8(4'd9, b);
    chk("R11 write zero keeps", b, 8'h04);
    wr8(4'd9, 8'h08);
    rd8(4'd9, b);
    chk("R11 other bit keeps", b, 8'h04);
    wr8(4'd9, 8'h04);
    rd8(4'd9, b);
    chk("R11 write one clears", b, 8'h00);
    wr16(4'd0, 16'hFFFF);
    do_tick(1);
    @(negedge clk); irq_ack = 4'b0001;
    @(negedge clk); irq_ack = 4'b0000;
    rd8(4'd9, b);
    chk("R11 ack clears", b, 8'h00);
    wr16(4'd0, 16'hFFFF);
    @(negedge clk); tick = 1'b1; irq_ack = 4'b0001;
    @(negedge clk); tick = 1'b0; irq_ack = 4'b0000;
    rd8(4'd9, b);
    chk("R11 set wins over ack", b, 8'h04);

    // R12 masking
    wr8(4'd8, 8'h10);
    gie = 1'b1;
    @(negedge clk);
    chk("R12 masked off", irq_req, 0);
    wr8(4'd8, 8'h04);
    gie = 1'b0;
    @(negedge clk);
    chk("R12 gie low", irq_req, 0);
    gie = 1'b1;
    @(negedge clk);
    chk("R12 request", irq_req, 4'b0001);
    rd8(4'd8, b);
    chk("R12 mask readback", b, 8'h04);
    gie = 1'b0;

    // R5 clear on compare A
    mode = 2'd1;
    wr16(4'd2, 16'h0005);
    wr16(4'd0, 16'h0000);
    clr_flags();
    do_tick(5);
    rd16(4'd0, w);
    chk("R5 reaches TOP", w, 16'h0005);
    do_tick(1);
    rd16(4'd0, w);
    chk("R5 cleared after TOP", w, 0);
    rd8(4'd9, b);
    chk("R5 flag A at TOP", b, 8'h10);
    wr16(4'd0, 16'hFFFE);
    clr_flags();
    do_tick(2);
    rd16(4'd0, w);
    chk("R5 above TOP wraps", w, 0);
    rd8(4'd9, b);
    chk("R5 above TOP overflow", b, 8'h04);

    // R9 capture from both sources
    mode = 2'd0;
    wr16(4'd0, 16'h1234);
    clr_flags();
    pulse_src(1'b0);
    rd16(4'd6, w);
    chk("R9 capture pin value", w, 16'h1234);
    rd8(4'd9, b);
    chk("R9 capture flag", b, 8'h20);
    cap_sel = 1'b1;
    wr16(4'd0, 16'h0777);
    clr_flags();
    pulse_src(1'b1);
    rd16(4'd6, w);
    chk("R9 comparator source", w, 16'h0777);
    cap_sel = 1'b0;

    // R10 capture register as TOP
    mode = 2'd2;
    wr16(4'd6, 16'h0003);
    wr16(4'd0, 16'h0000);
    clr_flags();
    do_tick(3);
    rd8(4'd9, b);
    chk("R10 no flag before TOP", b, 8'h00);
    do_tick(1);
    rd16(4'd0, w);
    chk("R10 cleared at TOP", w, 0);
    rd8(4'd9, b);
    chk("R10 flag at TOP", b, 8'h20);
    pulse_src(1'b0);
    rd16(4'd6, w);
    chk("R10 pin edge ignored", w, 16'h0003);

    // R6/R7/R4 random windows in free mode
    mode = 2'd0;
    for (int it = 0; it < 40; it++) begin
      int c, ca, cb, n, ef;
      c  = $urandom & 16'hFFFF;
      ca = (c + ($urandom % 10)) & 16'hFFFF;
      cb = (c + ($urandom % 10)) & 16'hFFFF;
      n  = 1 + ($urandom % 8);
      wr16(4'd2, ca[15:0]);
      wr16(4'd4, cb[15:0]);
      wr16(4'd0, c[15:0]);
      clr_flags();
      do_tick(n);
      rd16(4'd0, w);
      chk("R4 random count", w, (c + n) & 16'hFFFF);
      ef = (hit_after_block(c, n, ca) << 4) | (hit_after_block(c, n, cb) << 3)
         | (ovf_in(c, n) << 2);
      rd8(4'd9, b);
      chk("R6 R7 random flags", b, ef);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule